// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block gathers 48 input-only digital lines and makes them visible through a small byte-wide register window. The register window has eight byte offsets. It resynchronises every line to the local clock and exposes the lines as six bytes of eight lines each. It also watches every line for a change of level in either direction. Software chooses which of the six bytes may raise an interrupt. When a change occurs on any line of an armed byte group, the block latches a per-group flag and pulls an active-low interrupt request.

Software arms the groups by writing a 6-bit mask to offset 7. Reading offset 7 returns the latched group flags and a summary bit that is low while a request is pending. The same read acknowledges the request. The read data is a combinational function of the offset, so a peek with the read strobe low has no side effect. The six group bytes sit at offsets 0, 1, 2, 4, 5 and 6. Offset 3 is an unused gap.

Top module: `chgstate_din_port`

## Requirements
- R1: After reset, all enables are 0, all group flags are clear, irq_n is 1, and offset 7 reads 0x40.
- R2: Offsets 0, 1, 2, 4, 5 and 6 read groups 0 to 5 in that order. Bit n of group g's byte is input line g*8+n.
- R3: Offset 3 reads 0x00.
- R4: Each line passes through two synchronising flops. A line change that is applied before rising edge k first appears in its group byte after edge k+1.
- R5: On an enabled group, both a rising and a falling change on any line set that group's flag. Group g's flag is bit g of offset 7, and it is set after the third rising edge that follows the change.
- R6: A change on a group whose enable bit is 0 sets no flag and leaves irq_n high.
- R7: A write to offset 7 loads bit k of the write data as the enable of group k, for k = 0 to 5. Writing 0 disarms every group. Clearing an enable bit also drops that group's pending flag.
- R8: Bit 6 of offset 7 is the active-low request summary and always equals irq_n. It is 0 exactly when any group flag is set. Bit 7 reads 0.
- R9: A read strobe at offset 7 clears all group flags, and irq_n returns high after that edge.
- R10: A change that is detected in the same cycle as the acknowledging read is kept, so its group flag stays set after the read.
- R11: Writes to any offset other than 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 48 | Asynchronous digital input lines |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; at offset 7 it acknowledges |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
If the stored previous sample or a group flag is wrong, it shows at the ports as a spurious or missing low on irq_n and a wrong bit in the offset-7 byte. This appears at the third rising edge after the input change. A wrong enable register shows up only when a later change hits the affected group. For this reason each enable scenario ends by driving a fresh change and reading the status. A flag that the acknowledge fails to clear is visible one edge after the read.

// File: rtl/cos_pkg.sv
package cos_pkg;
    localparam int NGRP     = 6;
    localparam int GW       = 8;
    localparam int AW       = 3;
    localparam int NPIN     = NGRP * GW;
    localparam int SUM_BIT  = 6;
    localparam logic [AW-1:0] STAT_OFS = 3'd7;
    localparam logic [AW-1:0] HOLE_OFS = 3'd3;

    typedef enum logic [1:0] {
        SEL_GROUP,
        SEL_ZERO,
        SEL_STAT
    } sel_kind_t;

    typedef struct packed {
        sel_kind_t        kind;
        logic [AW-1:0]    grp;
    } sel_t;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [GW-1:0] wdata;
    } bus_req_t;

    // Offsets above the gap map one group lower.
    function automatic sel_t decode_ofs(input logic [AW-1:0] ofs);
        sel_t s;
        s.kind = SEL_GROUP;
        s.grp  = ofs;
        if (ofs == STAT_OFS)
            s.kind = SEL_STAT;
        else if (ofs == HOLE_OFS)
            s.kind = SEL_ZERO;
        else if (ofs > HOLE_OFS)
            s.grp = ofs - 3'd1;
        return s;
    endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cos_group_det.sv
module cos_group_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic         en_eff,
    input  logic         ack,
    output logic         stat
);
    logic [W-1:0] prev;
    logic         chg;
    logic         stat_d;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    // Either direction counts: any differing bit.
    assign chg    = |(lvl ^ prev);
    assign stat_d = en_eff & (chg | (stat & ~ack));

    always_ff @(posedge clk) begin
        if (rst) stat <= 1'b0;
        else     stat <= stat_d;
    end

    assert_disarmed_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
        !en_eff |=> !stat);
    assert_armed_change_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (en_eff && (lvl != prev)) |=> stat);
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && (lvl == prev)) |=> !stat);
    assert_flag_needs_change_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(stat) |-> $past(lvl != prev));
endmodule

// File: rtl/cos_regs.sv
module cos_regs
    import cos_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  logic [NPIN-1:0] lvl,
    input  logic [NGRP-1:0] stat,
    output logic [NGRP-1:0] en_eff,
    output logic            ack,
    output logic [GW-1:0]   rdata,
    output logic            irq_n
);
    logic [NGRP-1:0] en_q;
    sel_t            sel;
    logic            en_wr;

    assign sel   = decode_ofs(req.addr);
    assign en_wr = req.wr && (sel.kind == SEL_STAT);
    assign ack   = req.rd && (sel.kind == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= req.wdata[NGRP-1:0];
    end

    // A write that disarms a group also drops its flag in the same edge.
    assign en_eff = en_wr ? req.wdata[NGRP-1:0] : en_q;
    assign irq_n  = ~|stat;

    always_comb begin
        rdata = '0;
        unique case (sel.kind)
            SEL_GROUP: rdata = lvl[sel.grp*GW +: GW];
            SEL_STAT: begin
                rdata[NGRP-1:0] = stat;
                rdata[SUM_BIT]  = irq_n;
            end
            default:   rdata = '0;
        endcase
    end

    assert_foreign_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (req.addr != STAT_OFS)) |=> $stable(en_q));
    assert_enable_load_R7: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (en_q == $past(req.wdata[NGRP-1:0])));
endmodule

// File: rtl/chgstate_din_port.sv
module chgstate_din_port
    import cos_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [47:0]   pin_in,
    input  logic [2:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          irq_n
);
    bus_req_t        req;
    logic [NPIN-1:0] lvl;
    logic [NGRP-1:0] stat;
    logic [NGRP-1:0] en_eff;
    logic            ack;

    assign req.wr    = bus_wr;
    assign req.rd    = bus_rd;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;

    cos_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cos_group_det #(.W(GW)) u_det (
            .clk    (clk),
            .rst    (rst),
            .lvl    (lvl[g*GW +: GW]),
            .en_eff (en_eff[g]),
            .ack    (ack),
            .stat   (stat[g])
        );
    end

    cos_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .lvl    (lvl),
        .stat   (stat),
        .en_eff (en_eff),
        .ack    (ack),
        .rdata  (bus_rdata),
        .irq_n  (irq_n)
    );

    assert_summary_matches_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == STAT_OFS) |-> (bus_rdata[SUM_BIT] == irq_n && !bus_rdata[7]));
    assert_gap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == HOLE_OFS) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/chgstate_din_port_tb.sv
module chgstate_din_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] pins = '0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chgstate_din_port u_dut (
        .clk(clk), .rst(rst), .pin_in(pins), .bus_addr(addr),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_n(irq_n)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        addr = a; rd = 1'b0; #1; v = rdata;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
        addr = a; rd = 1'b1; #1; v = rdata;
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [2:0] ofs_of(input int g);
        return (g < 3) ? 3'(g) : 3'(g + 1);
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        peek(3'd7, v); check(v, 8'h40, "R1 status after reset");
        check({7'd0, irq_n}, 8'h01, "R1 irq_n after reset");
        peek(3'd0, v); check(v, 8'h00, "R1 group0 after reset");
    endtask

    task automatic t_offsets();
        logic [7:0] v;
        pins = 48'h6C_A5_3C_F0_81_7E;
        settle();
        for (int g = 0; g < 6; g++) begin
            peek(ofs_of(g), v);
            check(v, pins[g*8 +: 8], "R2 group byte map");
        end
        peek(3'd3, v); check(v, 8'h00, "R3 gap offset");
        peek(3'd7, v); check(v, 8'h40, "R6 no enables, no flags");
    endtask

    task automatic t_sync();
        logic [7:0] v;
        logic [7:0] old;
        old = pins[7:0];
        pins[0] = ~pins[0];
        @(posedge clk); @(negedge clk);
        peek(3'd0, v); check(v, old, "R4 one edge: not yet visible");
        @(posedge clk); @(negedge clk);
        peek(3'd0, v); check(v, old ^ 8'h01, "R4 two edges: visible");
        settle();
    endtask

    task automatic t_rise_fall();
        logic [7:0] v;
        reg_write(3'd7, 8'h3F);
        pins = '0; settle();
        reg_read(3'd7, v);
        peek(3'd7, v); check(v, 8'h40, "R9 clean start");
        pins[17] = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        peek(3'd7, v); check(v, 8'h40, "R5 not set after two edges");
        @(posedge clk); @(negedge clk);
        peek(3'd7, v); check(v, 8'h04, "R5 rising sets group2, R8 summary low");
        check({7'd0, irq_n}, 8'h00, "R8 irq_n low");
        reg_read(3'd7, v); check(v, 8'h04, "R9 read returns flags");
        peek(3'd7, v); check(v, 8'h40, "R9 cleared after read");
        check({7'd0, irq_n}, 8'h01, "R9 irq_n high after read");
        pins[17] = 1'b0; settle();
        peek(3'd7, v); check(v, 8'h04, "R5 falling sets group2");
        reg_read(3'd7, v);
        pins[47] = 1'b1; settle();
        peek(3'd7, v); check(v, 8'h20, "R5 rising sets group5");
        reg_read(3'd7, v);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        reg_write(3'd7, 8'h01);
        pins[26] = ~pins[26]; settle();
        peek(3'd7, v); check(v, 8'h40, "R6 disarmed group3 ignored");
        check({7'd0, irq_n}, 8'h01, "R6 irq_n stays high");
        pins[3] = ~pins[3]; settle();
        peek(3'd7, v); check(v, 8'h01, "R7 mask 0x01 arms group0");
        reg_write(3'd7, 8'h00);
        peek(3'd7, v); check(v, 8'h40, "R7 disarm drops pending flag");
        pins[3] = ~pins[3]; settle();
        peek(3'd7, v); check(v, 8'h40, "R7 write 0 disarms all");
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        reg_write(3'd7, 8'h3F);
        pins[33] = ~pins[33];
        @(posedge clk); @(posedge clk); @(negedge clk);
        addr = 3'd7; rd = 1'b1; #1;
        check(rdata, 8'h40, "R10 no flag before read edge");
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
        peek(3'd7, v); check(v, 8'h10, "R10 change at read edge kept");
        reg_read(3'd7, v);
        peek(3'd7, v); check(v, 8'h40, "R10 later read clears");
    endtask

    task automatic t_foreign_write();
        logic [7:0] v;
        reg_write(3'd0, 8'h00);
        reg_write(3'd3, 8'h00);
        reg_write(3'd6, 8'h00);
        pins[5] = ~pins[5]; settle();
        peek(3'd7, v); check(v, 8'h01, "R11 enables survive other writes");
        peek(3'd0, v); check(v, pins[7:0], "R11 group byte unaffected");
        reg_read(3'd7, v);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_offsets();
        t_sync();
        t_rise_fall();
        t_disabled();
        t_same_cycle();
        t_foreign_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule